// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Register

This block holds the sticky event flags of a four-channel capture/compare timer and turns them into one interrupt line. The rest of the timer supplies single-cycle event strobes: counter update, a capture/compare event per channel, and commutation. It also supplies a per-channel flag for input-capture mode, the raw trigger line with the slave-controller enable and gated-mode selection, and the break input level. Each event latches a flag bit. Software sees the flags in a 16-bit status register and clears them by writing zeros.

A channel in input-capture mode that captures again while its capture/compare flag is still set raises an overcapture flag. The break flag follows the break level and cannot be cleared while break is still asserted. An enable register masks the eight event flags. The interrupt output is a registered OR of the enabled flags. The register port is a simple synchronous bus with an address, a write strobe, write data and registered read data.

Top module: `tim_irq_status`

## Requirements
- R1: After synchronous reset the status register, the enable register, `irq` and `bus_rdata` are all zero.
- R2: At the first clock edge after an event, the matching status bit is set. The bits are: update bit 0, capture/compare channel n (1..4) bit n, commutation bit 5, trigger bit 6, break bit 7.
- R3: A write of the status register at byte address 0x10 clears each flag whose write-data bit is 0. Flags whose write-data bit is 1 keep their value.
- R4: Status bits 8, 13, 14 and 15 always read 0, even after 1s are written to them. Enable-register bits 15:8 always read 0.
- R5: A capture/compare event sets the channel's overcapture bit (bits 9..12 for channels 1..4) only when the channel is in input-capture mode and its capture/compare flag is already 1. A channel in compare mode never sets it.
- R6: The break flag is set on every clock edge at which the break input is 1. A write of 0 to bit 7 clears it only when the break input is 0 at that edge.
- R7: With the slave controller enabled and gated mode off, only a rising edge of the trigger line sets the trigger flag. With gated mode on, both edges set it. With the slave controller disabled, no edge sets it.
- R8: A hardware event and a software clear of the same flag at the same edge leave the flag set.
- R9: The enable register sits at byte address 0x0C. Bit k enables status bit k for k = 0..7. `irq` is a registered level that, after every edge, equals the OR of (status bit k AND enable bit k).
- R10: A read returns at the next edge the register selected at the previous edge. Reads have no side effect. Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| upd_evt | input | 1 | Counter update strobe |
| cc_evt | input | 4 | Capture/compare event strobe per channel |
| cc_capmode | input | 4 | 1 = channel in input-capture mode |
| trig_in | input | 1 | Raw trigger line |
| slave_en | input | 1 | Slave controller enabled |
| gated_mode | input | 1 | Gated slave mode selected |
| com_evt | input | 1 | Commutation strobe |
| brk_in | input | 1 | Break input level, active high |
| irq | output | 1 | Interrupt request level |

## Verification
A flag and `irq` reflect an event or a write at the first rising edge after the stimulus. `bus_rdata` shows that state one edge later, because it is registered from the address presented at that edge. The bench drives every stimulus on a falling edge. It checks `irq` at the next falling edge and performs each status read as a separate one-cycle access, sampled at the falling edge after it. Sweeps cover every event source against three enable masks, every channel in both modes with and without a pending flag, and all trigger mode combinations in both edge directions.

// File: rtl/tim_sr_pkg.sv
package tim_sr_pkg;
  localparam int TIM_NUM_CH = 4;
  localparam int TIM_DATA_W = 16;
  localparam int TIM_ADDR_W = 8;
  localparam int TIM_SR_OFS = 16;  // status register byte address
  localparam int TIM_IER_OFS = 12; // enable register byte address
endpackage

// File: rtl/tim_trig_det.sv
module tim_trig_det (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic slave_en,
  input  logic gated_mode,
  output logic evt_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= trig_in;
  end

  assign rise  = trig_in & ~prev_q;
  assign fall  = ~trig_in & prev_q;
  assign evt_o = slave_en & (rise | (gated_mode & fall));

  // R7
  fall_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!gated_mode && $fell(trig_in)) |-> !evt_o);
endmodule

// File: rtl/tim_cc_chan.sv
module tim_cc_chan (
  input  logic clk,
  input  logic rst,
  input  logic cap_evt,
  input  logic cap_mode,
  input  logic clr_cc,
  input  logic clr_ovc,
  output logic cc_d,
  output logic cc_q,
  output logic ovc_q
);
  logic ovc_d;

  assign cc_d  = cap_evt | (cc_q & ~clr_cc);
  assign ovc_d = (cap_evt & cap_mode & cc_q) | (ovc_q & ~clr_ovc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q  <= 1'b0;
      ovc_q <= 1'b0;
    end else begin
      cc_q  <= cc_d;
      ovc_q <= ovc_d;
    end
  end

  // R5
  ovc_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && cap_mode && cc_q) |=> ovc_q);
  // R5
  ovc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovc_q && !cap_mode) |=> !ovc_q);
  // R8
  cc_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cc_q);
endmodule

// File: rtl/tim_irq_status.sv
module tim_irq_status
  import tim_sr_pkg::*;
#(
  parameter int NUM_CH  = TIM_NUM_CH,
  parameter int DATA_W  = TIM_DATA_W,
  parameter int ADDR_W  = TIM_ADDR_W,
  parameter int SR_OFS  = TIM_SR_OFS,
  parameter int IER_OFS = TIM_IER_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_evt,
  input  logic [NUM_CH-1:0] cc_evt,
  input  logic [NUM_CH-1:0] cc_capmode,
  input  logic              trig_in,
  input  logic              slave_en,
  input  logic              gated_mode,
  input  logic              com_evt,
  input  logic              brk_in,
  output logic              irq
);
  localparam int COM_BIT = NUM_CH + 1;
  localparam int TRG_BIT = NUM_CH + 2;
  localparam int BRK_BIT = NUM_CH + 3;
  localparam int SRC_W   = NUM_CH + 4;
  localparam int OVC_LSB = NUM_CH + 5;

  logic              sr_wr, ier_wr;
  logic [DATA_W-1:0] clr_mask;
  logic              trg_evt;
  logic              upd_q, com_q, trg_q, brk_q;
  logic              upd_d, com_d, trg_d, brk_d;
  logic [NUM_CH-1:0] cc_d, cc_q, ovc_q;
  logic [SRC_W-1:0]  src_d, src_q, ier_d, ier_q;
  logic [DATA_W-1:0] sr_view, rd_mux;

  assign sr_wr    = bus_we && (bus_addr == ADDR_W'(SR_OFS));
  assign ier_wr   = bus_we && (bus_addr == ADDR_W'(IER_OFS));
  assign clr_mask = sr_wr ? ~bus_wdata : '0;

  tim_trig_det u_trig (
    .clk        (clk),
    .rst        (rst),
    .trig_in    (trig_in),
    .slave_en   (slave_en),
    .gated_mode (gated_mode),
    .evt_o      (trg_evt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tim_cc_chan u_ch (
      .clk      (clk),
      .rst      (rst),
      .cap_evt  (cc_evt[i]),
      .cap_mode (cc_capmode[i]),
      .clr_cc   (clr_mask[1+i]),
      .clr_ovc  (clr_mask[OVC_LSB+i]),
      .cc_d     (cc_d[i]),
      .cc_q     (cc_q[i]),
      .ovc_q    (ovc_q[i])
    );
  end

  // hardware set dominates a same-edge clear
  assign upd_d = upd_evt | (upd_q & ~clr_mask[0]);
  assign com_d = com_evt | (com_q & ~clr_mask[COM_BIT]);
  assign trg_d = trg_evt | (trg_q & ~clr_mask[TRG_BIT]);
  assign brk_d = brk_in  | (brk_q & ~clr_mask[BRK_BIT]);

  assign src_d = {brk_d, trg_d, com_d, cc_d, upd_d};
  assign src_q = {brk_q, trg_q, com_q, cc_q, upd_q};
  assign ier_d = ier_wr ? bus_wdata[SRC_W-1:0] : ier_q;

  assign sr_view = DATA_W'({ovc_q, 1'b0, src_q});

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(SR_OFS))       rd_mux = sr_view;
    else if (bus_addr == ADDR_W'(IER_OFS)) rd_mux = DATA_W'(ier_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q     <= 1'b0;
      com_q     <= 1'b0;
      trg_q     <= 1'b0;
      brk_q     <= 1'b0;
      ier_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      upd_q     <= upd_d;
      com_q     <= com_d;
      trg_q     <= trg_d;
      brk_q     <= brk_d;
      ier_q     <= ier_d;
      irq       <= |(src_d & ier_d);
      bus_rdata <= rd_mux;
    end
  end

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(src_q & ier_q));
  // R6
  brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    brk_in |=> brk_q);
  // R8
  upd_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> upd_q);
  // R3
  keep_on_one_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && sr_wr && bus_wdata[0]) |=> upd_q);
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:DATA_W-3] == 3'b000) && !bus_rdata[SRC_W]);
endmodule

// File: tb/tim_irq_status_bench.sv
module tim_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SR  = 8'h10;
  localparam logic [7:0] IER = 8'h0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        upd_evt = 1'b0;
  logic [3:0]  cc_evt = '0;
  logic [3:0]  cc_capmode = '0;
  logic        trig_in = 1'b0;
  logic        slave_en = 1'b0;
  logic        gated_mode = 1'b0;
  logic        com_evt = 1'b0;
  logic        brk_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tim_irq_status u_tim_irq_status (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_evt(upd_evt),
    .cc_evt(cc_evt), .cc_capmode(cc_capmode), .trig_in(trig_in),
    .slave_en(slave_en), .gated_mode(gated_mode), .com_evt(com_evt),
    .brk_in(brk_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic fire(input int s);
    case (s)
      0: upd_evt = 1'b1;
      5: com_evt = 1'b1;
      6: begin slave_en = 1'b1; gated_mode = 1'b0; trig_in = 1'b1; end
      7: brk_in = 1'b1;
      default: cc_evt[s-1] = 1'b1;
    endcase
    @(negedge clk);
    upd_evt = 1'b0; com_evt = 1'b0; cc_evt = '0; brk_in = 1'b0; trig_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    logic [7:0] en;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'h0000);
    check("R1 rdata", bus_rdata, 16'h0000);
    rd(SR, d);  check("R1 status", d, 16'h0000);
    rd(IER, d); check("R1 enable", d, 16'h0000);

    // R2/R9 sweep over each source with three masks
    for (int s = 0; s < 8; s++) begin
      wr(SR, 16'h0000);
      fire(s);
      rd(SR, d); check("R2 source bit", d, 16'(1 << s));
      for (int k = 0; k < 3; k++) begin
        en = (k == 0) ? 8'(1 << s) : (k == 1) ? ~8'(1 << s) : 8'hFF;
        wr(IER, {8'h00, en});
        check("R9 irq mask", {15'd0, irq}, {15'd0, en[s]});
        rd(IER, d); check("R9 enable readback", d, {8'h00, en});
      end
      wr(SR, 16'hFFFF);
      rd(SR, d); check("R3 write one keeps", d, 16'(1 << s));
      check("R9 irq still high", {15'd0, irq}, 16'h0001);
      wr(SR, 16'h0000);
      check("R9 irq drops", {15'd0, irq}, 16'h0000);
      rd(SR, d); check("R3 write zero clears", d, 16'h0000);
    end

    // R5 overcapture sweep
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(SR, 16'h0000);
        cc_capmode = m[0] ? 4'(1 << i) : 4'h0;
        cc_evt = 4'(1 << i); @(negedge clk); cc_evt = '0;
        rd(SR, d); check("R5 first capture", d, 16'(1 << (1+i)));
        cc_evt = 4'(1 << i); @(negedge clk); cc_evt = '0;
        rd(SR, d); check("R5 second capture", d, 16'((1 << (1+i)) | (m << (9+i))));
      end
    end
    cc_capmode = '0;

    // R7 trigger sweep
    for (int se = 0; se < 2; se++) begin
      for (int g = 0; g < 2; g++) begin
        slave_en = se[0]; gated_mode = g[0];
        wr(SR, 16'h0000);
        trig_in = 1'b1; @(negedge clk);
        rd(SR, d); check("R7 rising edge", d, 16'(se << 6));
        wr(SR, 16'h0000);
        trig_in = 1'b0; @(negedge clk);
        rd(SR, d); check("R7 falling edge", d, 16'((se & g) << 6));
      end
    end
    slave_en = 1'b0; gated_mode = 1'b0;

    // R6 break clear refused while active
    wr(SR, 16'h0000);
    brk_in = 1'b1; @(negedge clk);
    rd(SR, d); check("R6 break set", d, 16'h0080);
    wr(SR, 16'h0000);
    rd(SR, d); check("R6 clear refused", d, 16'h0080);
    brk_in = 1'b0; @(negedge clk);
    rd(SR, d); check("R6 sticky after release", d, 16'h0080);
    wr(SR, 16'h0000);
    rd(SR, d); check("R6 clear accepted", d, 16'h0000);

    // R8 set beats same-edge clear
    fire(0); fire(2); fire(5);
    rd(SR, d); check("R8 preset", d, 16'h0025);
    bus_addr = SR; bus_wdata = 16'h0000; bus_we = 1'b1;
    upd_evt = 1'b1; cc_evt = 4'b0010;
    @(negedge clk);
    bus_we = 1'b0; upd_evt = 1'b0; cc_evt = '0;
    rd(SR, d); check("R8 set wins", d, 16'h0005);

    // R4 reserved bits, R10 other addresses
    wr(SR, 16'h0000);
    for (int s = 0; s < 8; s++) fire(s);
    cc_capmode = 4'hF;
    cc_evt = 4'hF; @(negedge clk);
    cc_evt = 4'hF; @(negedge clk); cc_evt = '0;
    cc_capmode = 4'h0;
    rd(SR, d); check("R4 all flags", d, 16'h1EFF);
    wr(SR, 16'hFFFF);
    rd(SR, d); check("R4 reserved stay zero", d, 16'h1EFF);
    wr(SR, 16'h00F0);
    rd(SR, d); check("R3 partial clear", d, 16'h00F0);
    wr(IER, 16'hFFFF);
    rd(IER, d); check("R4 enable upper zero", d, 16'h00FF);
    rd(8'h00, d); check("R10 unmapped read", d, 16'h0000);
    wr(8'h04, 16'h0000);
    rd(SR, d); check("R10 unmapped write", d, 16'h00F0);
    rd(SR, d); check("R10 read no side effect", d, 16'h00F0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule